// File: doc/BRIEF.md
# SPI Master Word Shifter

This block moves a single word of 1 to 32 bits across a four-wire serial link as the controlling end. It generates the serial clock and the outgoing data line, and it samples the incoming data line. A one-cycle `start` pulse captures the word, its length, the clock polarity and phase, the half-period delay and two suppression flags. The block then runs through the bits most significant first and finishes with a one-cycle `done` pulse. The received bits appear on `rx_word` in the same cycle, right-aligned.

The control path is a three-state machine. In `ST_IDLE` the machine waits for `start`. In `ST_LEAD` it runs the first half of a bit, and in `ST_TRAIL` the second half. The transitions are: IDLE→LEAD on an accepted start (`T_ACCEPT`), LEAD→TRAIL when the half-period timer expires (`T_HALF`), TRAIL→LEAD on expiry with bits still to send (`T_NEXT`), and TRAIL→IDLE on expiry after the last bit (`T_FINISH`). Every half-period lasts `half_delay + 1` system clocks. A delay of zero therefore gives one clock per half-period. The outgoing line is rewritten only when the next bit differs from the value it already carries.

Top module: `spi_word_master`

## Requirements
- R1: `bit_count` values 1..32 select the word length; 0 or values above 32 act as 32. Bit `bit_count-1` of `tx_word` is driven first and bit 0 last. Bits of `tx_word` above the length never appear on `mosi`.
- R2: On `done`, `rx_word` holds the sampled bits in its low `bit_count` bits, first-sampled bit highest, with all upper bits zero. `done` is high for exactly one cycle, and `rx_word` holds its value until the next `done`.
- R3: While idle, `sck` equals the polarity captured at the last accepted start (0 after reset). Changing the `cpol` input while idle does not move `sck`. During a word, `sck` makes exactly `bit_count` excursions to the inverse level.
- R4: With phase 0, each bit presents `mosi` while `sck` is idle, one half-period before `sck` goes active. `miso` is sampled at the end of the active half-period, just as `sck` returns to idle.
- R5: With phase 1, each bit drives `sck` active and presents `mosi` in the same cycle. `sck` returns to idle one half-period later, and `miso` is sampled at the end of the following half-period.
- R6: With `no_tx` set at start, `mosi` does not change at any point during the word.
- R7: With `no_rx` set at start, `miso` is ignored and `rx_word` is zero at `done`.
- R8: Every `sck` level lasts `half_delay+1` clocks within a word. `busy` is high for exactly `2*bit_count*(half_delay+1)` cycles. `busy` rises the cycle after start and falls in the cycle `done` rises.
- R9: A `start` pulse while `busy` is high is ignored. The word in progress keeps its length, polarity and data, and no extra word follows.
- R10: After reset, `sck`, `mosi`, `busy`, `done` and `rx_word` are all zero.
- R11: `mosi` changes only in the first cycle of a bit. It toggles exactly once per change of value between consecutive outgoing bits, plus once at the first bit if that bit differs from the line's prior level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to shift a word |
| tx_word | input | 32 | Outgoing word, right-aligned |
| bit_count | input | 6 | Word length, 1..32 |
| half_delay | input | 8 | Extra system clocks per half-period |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Clock phase select |
| no_tx | input | 1 | Hold `mosi` for the whole word |
| no_rx | input | 1 | Ignore `miso`, shift zeros |
| miso | input | 1 | Serial data from the target |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the target |
| busy | output | 1 | Word in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_word | output | 32 | Received word, right-aligned |

## Verification
A bench target model loops back a word of its own in each of the four polarity/phase combinations, so a swapped sample or drive edge shows up as a shifted or corrupted word. The word lengths used are 1, 5, 8, 13, 16 and 32, with delays from 0 to 3. These tell apart an off-by-one in left-justification, the count, or the half-period timer, which the busy length and clock spacing expose. Data patterns with long runs and with alternating bits separate drive-on-change from drive-always via the `mosi` toggle count. High junk bits in `tx_word` catch leakage past the word length. Suppress-flag words, and a start pulse injected mid-word with different settings, show whether the captured configuration is really held.

// File: rtl/spiw_pkg.sv
package spiw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2
    } spiw_state_e;

endpackage

// File: rtl/spiw_tick.sv
// Half-period timer: reload on every phase entry, count down to zero.
module spiw_tick #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    output logic             expired
);

    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/spiw_shift.sv
// Data path: left-justified transmit register, drive-on-change output,
// receive accumulator.
module spiw_shift #(
    parameter int W     = 32,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    input  logic             sample,
    input  logic [W-1:0]     tx_word,
    input  logic [CNT_W-1:0] nbits,
    input  logic             no_tx,
    input  logic             no_rx,
    input  logic             miso,
    output logic             mosi,
    output logic [W-1:0]     rx_next
);

    logic [W-1:0] txsh_q;
    logic [W-1:0] rxacc_q;
    logic [W-1:0] aligned;
    logic         trk_q;
    logic         nxt_bit;

    assign aligned = tx_word << (W - int'(nbits));
    assign nxt_bit = txsh_q[W-2];
    assign rx_next = {rxacc_q[W-2:0], (no_rx ? 1'b0 : miso)};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txsh_q  <= '0;
            rxacc_q <= '0;
            trk_q   <= 1'b0;
            mosi    <= 1'b0;
        end else if (load) begin
            txsh_q  <= aligned;
            rxacc_q <= '0;
            // tracked level starts opposite to the first bit so it is driven
            trk_q   <= ~aligned[W-1];
            if (!no_tx) begin
                mosi  <= aligned[W-1];
                trk_q <= aligned[W-1];
            end
        end else begin
            if (sample) begin
                rxacc_q <= rx_next;
            end
            if (advance) begin
                txsh_q <= {txsh_q[W-2:0], 1'b0};
                if (!no_tx && (nxt_bit != trk_q)) begin
                    mosi  <= nxt_bit;
                    trk_q <= nxt_bit;
                end
            end
        end
    end

endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
    import spiw_pkg::*;
#(
    parameter int W     = 32,
    parameter int DLY_W = 8,
    localparam int CNT_W = $clog2(W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [W-1:0]     tx_word,
    input  logic [CNT_W-1:0] bit_count,
    input  logic [DLY_W-1:0] half_delay,
    input  logic             cpol,
    input  logic             cpha,
    input  logic             no_tx,
    input  logic             no_rx,
    input  logic             miso,
    output logic             sck,
    output logic             mosi,
    output logic             busy,
    output logic             done,
    output logic [W-1:0]     rx_word
);

    localparam logic [CNT_W-1:0] FULL_N = CNT_W'(W);

    spiw_state_e      state_q, state_d;
    logic             cpol_q, cpha_q, ntx_q, nrx_q;
    logic [DLY_W-1:0] dly_q;
    logic [CNT_W-1:0] nbits_q, left_q, eff_n;
    logic             sck_q, done_q;
    logic [W-1:0]     rx_word_q, rx_next;
    logic             expired, phase_end, accept, last_bit;
    logic             ntx_now, nrx_now;

    assign eff_n     = ((bit_count == '0) || (bit_count > FULL_N)) ? FULL_N : bit_count;
    assign accept    = (state_q == ST_IDLE) && start;
    assign phase_end = (state_q != ST_IDLE) && expired;
    assign last_bit  = (left_q == CNT_W'(1));
    assign ntx_now   = (state_q == ST_IDLE) ? no_tx : ntx_q;
    assign nrx_now   = nrx_q;

    spiw_tick #(.DLY_W(DLY_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept | phase_end),
        .load_val (accept ? half_delay : dly_q),
        .expired  (expired)
    );

    spiw_shift #(.W(W), .CNT_W(CNT_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .advance ((state_q == ST_TRAIL) && phase_end && !last_bit),
        .sample  ((state_q == ST_TRAIL) && phase_end),
        .tx_word (tx_word),
        .nbits   (eff_n),
        .no_tx   (ntx_now),
        .no_rx   (nrx_now),
        .miso    (miso),
        .mosi    (mosi),
        .rx_next (rx_next)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: T_ACCEPT, T_HALF, T_NEXT, T_FINISH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)     state_d = ST_LEAD;
            ST_LEAD:  if (phase_end) state_d = ST_TRAIL;
            ST_TRAIL: if (phase_end) state_d = last_bit ? ST_IDLE : ST_LEAD;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // outputs and captured configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpol_q    <= 1'b0;
            cpha_q    <= 1'b0;
            ntx_q     <= 1'b0;
            nrx_q     <= 1'b0;
            dly_q     <= '0;
            nbits_q   <= '0;
            left_q    <= '0;
            sck_q     <= 1'b0;
            done_q    <= 1'b0;
            rx_word_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cpol_q  <= cpol;
                        cpha_q  <= cpha;
                        ntx_q   <= no_tx;
                        nrx_q   <= no_rx;
                        dly_q   <= half_delay;
                        nbits_q <= eff_n;
                        left_q  <= eff_n;
                        sck_q   <= cpha ? ~cpol : cpol;
                    end
                end
                ST_LEAD: begin
                    if (phase_end) sck_q <= ~sck_q;
                end
                ST_TRAIL: begin
                    if (phase_end) begin
                        if (last_bit) begin
                            done_q    <= 1'b1;
                            rx_word_q <= rx_next;
                            sck_q     <= cpol_q;
                        end else begin
                            left_q <= left_q - 1'b1;
                            sck_q  <= cpha_q ? ~cpol_q : cpol_q;
                        end
                    end
                end
                default: sck_q <= cpol_q;
            endcase
        end
    end

    assign sck     = sck_q;
    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;
    assign rx_word = rx_word_q;

endmodule

// File: rtl/spiw_checker.sv
module spiw_checker
    import spiw_pkg::*;
#(
    parameter int W     = 32,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             sck,
    input logic             mosi,
    input logic [W-1:0]     rx_word,
    input logic             cpol_q,
    input logic             ntx_q,
    input logic [CNT_W-1:0] nbits_q,
    input logic             phase_end,
    input spiw_state_e      state_q
);

    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((rx_word >> nbits_q) == '0));

    a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck == cpol_q));

    a_r6_no_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && ntx_q) |-> $stable(mosi));

    a_r8_sck_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$stable(sck)) |-> $past(phase_end));

    a_r9_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(nbits_q) && $stable(cpol_q)));

    a_r11_mosi_bit_start: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi) |-> ((state_q == ST_LEAD) && ($past(state_q) != ST_LEAD)));

endmodule

bind spi_word_master spiw_checker #(.W(W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .sck       (sck),
    .mosi      (mosi),
    .rx_word   (rx_word),
    .cpol_q    (cpol_q),
    .ntx_q     (ntx_q),
    .nbits_q   (nbits_q),
    .phase_end (phase_end),
    .state_q   (state_q)
);

// File: tb/tb_spi_word_master.sv
module tb_spi_word_master;

    typedef struct {
        int          n;
        int          d;
        logic        pol;
        logic        pha;
        logic [31:0] sw;
        logic [31:0] rx_exp;
        logic [31:0] cap_exp;
        int          tog_exp;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] tx_word = '0;
    logic [5:0]  bit_count = 6'd8;
    logic [7:0]  half_delay = '0;
    logic        cpol = 1'b0, cpha = 1'b0, no_tx = 1'b0, no_rx = 1'b0;
    logic        miso = 1'b0;
    logic        sck, mosi, busy, done;
    logic [31:0] rx_word;

    int n_checks = 0;
    int n_fail   = 0;
    item_t q[$];

    spi_word_master dut (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
        .bit_count(bit_count), .half_delay(half_delay), .cpol(cpol),
        .cpha(cpha), .no_tx(no_tx), .no_rx(no_rx), .miso(miso),
        .sck(sck), .mosi(mosi), .busy(busy), .done(done), .rx_word(rx_word)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lowmask(input int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
    endfunction

    // target model and scoreboard monitor, all at the falling edge
    item_t       cur;
    logic [31:0] sr, cap;
    logic        psck, pbusy = 1'b0, pmosi = 1'b0;
    int          leads, gap, gap_bad, bcnt, togs;

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !pbusy && q.size() > 0) begin
                cur = q[0];
                sr = cur.sw << (32 - cur.n);
                cap = '0; leads = 0; gap = 1; gap_bad = 0; bcnt = 0; togs = 0;
                psck = cur.pol;
                if (mosi != pmosi) togs++;
                if (!cur.pha) begin miso = sr[31]; sr = sr << 1; end
                if (sck != psck) begin
                    leads++;
                    miso = sr[31]; sr = sr << 1;
                end
                psck = sck;
            end else if (busy || done) begin
                if (mosi != pmosi) togs++;
                if (sck != psck) begin
                    if (gap != cur.d + 1) gap_bad++;
                    gap = 1;
                    if (sck != cur.pol) begin
                        leads++;
                        if (!cur.pha) cap = {cap[30:0], mosi};
                        else begin miso = sr[31]; sr = sr << 1; end
                    end else begin
                        if (!cur.pha) begin miso = sr[31]; sr = sr << 1; end
                        else cap = {cap[30:0], mosi};
                    end
                end else begin
                    gap++;
                end
                psck = sck;
            end
            if (busy) bcnt++;
            if (done) begin
                if (q.size() == 0) begin
                    check(0, "R9 unexpected done", 1, 0);
                end else begin
                    cur = q.pop_front();
                    check(rx_word == cur.rx_exp, "R2/R4/R5/R7 rx_word", rx_word, cur.rx_exp);
                    check((cap & lowmask(cur.n)) == cur.cap_exp, "R1/R4/R5/R6 mosi bits", cap & lowmask(cur.n), cur.cap_exp);
                    check(bcnt == 2 * cur.n * (cur.d + 1), "R8 busy length", bcnt, 2 * cur.n * (cur.d + 1));
                    check(gap_bad == 0, "R8 half-period spacing", gap_bad, 0);
                    check(leads == cur.n, "R3 sck pulses", leads, cur.n);
                    check(sck == cur.pol && !busy, "R3 idle level after word", sck, cur.pol);
                    check(togs == cur.tog_exp, "R11 mosi toggles", togs, cur.tog_exp);
                end
            end
            pbusy = busy;
            pmosi = mosi;
        end
    end

    // driver: pushes the expected result, then issues the start pulse
    task automatic run_word(input int n, input int d, input logic pol, input logic pha,
                            input logic ntx, input logic nrx, input logic [31:0] tx,
                            input logic [31:0] sw, input bit poke);
        item_t it;
        logic prev;
        do @(negedge clk); while (busy || done);
        it.n = n; it.d = d; it.pol = pol; it.pha = pha; it.sw = sw;
        it.rx_exp = nrx ? 32'h0 : (sw & lowmask(n));
        it.cap_exp = ntx ? (mosi ? lowmask(n) : 32'h0) : (tx & lowmask(n));
        it.tog_exp = 0;
        prev = mosi;
        if (!ntx) begin
            for (int i = n - 1; i >= 0; i--) begin
                if (tx[i] != prev) it.tog_exp++;
                prev = tx[i];
            end
        end
        q.push_back(it);
        tx_word = tx; bit_count = 6'(n); half_delay = 8'(d);
        cpol = pol; cpha = pha; no_tx = ntx; no_rx = nrx;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R9: a second request with different settings mid-word
            repeat (5) @(negedge clk);
            tx_word = ~tx; bit_count = 6'd3; cpol = ~pol; half_delay = 8'd0; no_rx = ~nrx;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        cpol = 1'b1;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(sck == 1'b0 && mosi == 1'b0, "R10 sck/mosi after reset", {sck, mosi}, 0);
        check(!busy && !done && rx_word == 0, "R10 busy/done/rx after reset", {busy, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(sck == 1'b0, "R3 idle level ignores cpol input", sck, 0);

        run_word(8, 0, 0, 0, 0, 0, 32'hFFFF_FFA5, 32'h3C, 0);   // R4 mode 0, R1 high junk
        run_word(8, 0, 0, 1, 0, 0, 32'h0000_005A, 32'hC3, 0);   // R5 mode 1
        run_word(8, 1, 1, 0, 0, 0, 32'h0000_00F0, 32'h81, 0);   // R4 mode 2
        run_word(8, 2, 1, 1, 0, 0, 32'h0000_0055, 32'hAA, 0);   // R5 mode 3
        run_word(32, 0, 0, 0, 0, 0, 32'hDEAD_BEEF, 32'h1234_5678, 0); // R1 full
        run_word(1, 0, 1, 1, 0, 0, 32'h0000_0001, 32'h1, 0);    // R1 single
        run_word(1, 1, 0, 0, 0, 0, 32'hFFFF_FFFE, 32'h1, 0);    // R1 single
        run_word(13, 3, 0, 1, 0, 0, 32'h0000_1B35, 32'h0ACE, 0);// R8 delay 3
        run_word(16, 0, 0, 0, 0, 0, 32'h0000_FF00, 32'h00FF, 0);// R11 runs
        run_word(16, 1, 0, 0, 1, 0, 32'h0000_A5A5, 32'h5A5A, 0);// R6 no_tx
        run_word(16, 0, 1, 0, 0, 1, 32'h0000_1234, 32'hFFFF, 0);// R7 no_rx
        run_word(5, 0, 0, 1, 1, 1, 32'h0000_0015, 32'h1F, 0);   // R6 R7 both
        run_word(8, 3, 0, 1, 0, 0, 32'h0000_00C6, 32'h39, 1);   // R9 mid-word start

        // R9: no further word after the ignored request
        repeat (6) @(negedge clk);
        check(!busy, "R9 no extra word", busy, 0);
        // R2: rx_word holds after done
        check(rx_word == 32'h39, "R2 rx_word held", rx_word, 32'h39);
        // R3: cpol input change while idle does not move sck
        cpol = 1'b1;
        repeat (2) @(negedge clk);
        check(sck == 1'b0, "R3 sck ignores idle cpol input", sck, 0);
        check(q.size() == 0, "R2 all results returned", q.size(), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule